// File: doc/BRIEF.md
# Processor Performance Monitor Unit

This block counts activity inside a processor core for profiling software. It holds three 32-bit counters. A dedicated cycle counter advances with the clock, either on every clock or once per 64 clocks. Two general counters each take their input from one line of an event pulse bus. An 8-bit selector chooses that line. General counters cannot be switched off one by one, so software parks one by selecting a code that never fires.

Software reaches the unit through a single-cycle register port. A valid/write strobe pair, a 2-bit address and 32-bit write data go in, and read data comes back combinationally. Address 0 is a shared control and status register. Addresses 1 to 3 hold the counters. Each counter sets an overflow flag when it wraps. One interrupt line is the OR of all flags, each masked by its own enable. Flags are cleared by writing ones, so software can read the control register and write the same value back to acknowledge an interrupt without disturbing anything else.

Top module: `perf_monitor`

## Requirements
- R1: Address 0 reads the control register; addresses 1, 2 and 3 read the cycle counter, general counter 0 and general counter 1. Read data reflects the current state in the same cycle. A write to a counter address loads the write data into that counter, and the load takes priority over any increment in that cycle.
- R2: Control bit 0 is the global enable. While it is 0, no counter and no prescaler advances.
- R3: When enabled, the cycle counter advances on every clock while control bit 3 is 0. While bit 3 is 1 it advances only on clocks where a 6-bit prescaler holds 63. The prescaler counts enabled clocks, starts at 0 after reset and wraps at 64.
- R4: General counter 0 takes its selector from control bits 27:20 and general counter 1 from bits 19:12. A code c below 19 adds one on each enabled clock where event input bit c is high. Any other code, including 0x20 and 0xFF, never counts.
- R5: Writing control bit 1 as 1 clears both general counters. Writing control bit 2 as 1 clears the cycle counter and the prescaler. Both clears act in that write's cycle in place of an increment, and both bits always read back as 0.
- R6: Overflow flags sit at control bit 8 (general 0), bit 9 (general 1) and bit 10 (cycle counter). A flag is set when its counter increments from 0xFFFFFFFF to 0. Loading 0xFFFFFFFF by a write does not set it.
- R7: A control write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. If a wrap lands in the same cycle as the clearing write, the flag ends up set.
- R8: Interrupt enables sit at control bit 4 (general 0), bit 5 (general 1) and bit 6 (cycle counter). The irq output is high exactly while some flag and its enable are both 1.
- R9: Control bits 31:28, 11, 7 and 2:1 read as 0. All state is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_in | input | 19 | Event pulse bus from the core |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The bench loads counters just below the wrap point and then drives events or enabled clocks across the boundary. A design that flagged a software load of the top value, or missed the wrap, reports the wrong flag bits. It clears a flag in the same cycle as a fresh wrap; a design where the clear wins drops a real overflow and irq falls. It also selects the parked code 0x20 and the cycle code 0xFF on general counters with every event line high. A selector that decoded those codes, or indexed past the bus, would count. It runs the prescaler for more than two periods, so an off-by-one divider gives a wrong cycle count. It also checks that the reset bits read back as 0 and act in their own cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_CNT  = 3;

    // counter indices
    localparam int IDX_CYC  = 0;
    localparam int IDX_GEN0 = 1;
    localparam int IDX_GEN1 = 2;

    // control register bit positions
    localparam int B_EN     = 0;
    localparam int B_RSTGEN = 1;
    localparam int B_RSTCYC = 2;
    localparam int B_DIV    = 3;
    localparam int B_IE_LO  = 4;
    localparam int B_OV_LO  = 8;
    localparam int B_SEL1   = 12;
    localparam int B_SEL0   = 20;

    // flag / enable order inside the 3-bit groups: gen0, gen1, cycle
    localparam int F_GEN0   = 0;
    localparam int F_GEN1   = 1;
    localparam int F_CYC    = 2;

endpackage

// File: rtl/pmu_event_select.sv
module pmu_event_select #(
    parameter int NUM_EVENTS = 19,
    parameter int SEL_W      = 8
) (
    input  logic [NUM_EVENTS-1:0] evt,
    input  logic [SEL_W-1:0]      sel,
    output logic                  hit
);
    // codes outside the bus (park code, cycle code) never hit
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVENTS; i++) begin
            if (sel == SEL_W'(i)) hit = evt[i];
        end
    end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (ld) begin
            cnt_d = ld_val;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = (cnt_q == '1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_EVENTS = 19,
    parameter int SEL_W      = 8,
    parameter int PRESC_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [1:0]            reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_EVENTS-1:0] evt_in,
    output logic                  irq
);
    typedef struct packed {
        logic               en;
        logic               div;
        logic [2:0]         ie;
        logic [2:0]         ovf;
        logic [SEL_W-1:0]   sel0;
        logic [SEL_W-1:0]   sel1;
        logic [PRESC_W-1:0] presc;
    } state_t;

    state_t st_d, st_q;

    logic             wr_ctl;
    logic             clr_gen, clr_cyc;
    logic [NUM_CNT-1:0] clr_v, ld_v, inc_v, wrap_v;
    logic [CNT_W-1:0] cnt_v [NUM_CNT];
    logic             hit0, hit1;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

    assign wr_ctl  = reg_valid && reg_write && (reg_addr == 2'd0);
    assign clr_gen = wr_ctl && reg_wdata[B_RSTGEN];
    assign clr_cyc = wr_ctl && reg_wdata[B_RSTCYC];

    pmu_event_select #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel0 (
        .evt(evt_in), .sel(st_q.sel0), .hit(hit0)
    );
    pmu_event_select #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel1 (
        .evt(evt_in), .sel(st_q.sel1), .hit(hit1)
    );

    always_comb begin
        clr_v[IDX_CYC]  = clr_cyc;
        clr_v[IDX_GEN0] = clr_gen;
        clr_v[IDX_GEN1] = clr_gen;
        inc_v[IDX_CYC]  = st_q.en && (!st_q.div || (st_q.presc == '1));
        inc_v[IDX_GEN0] = st_q.en && hit0;
        inc_v[IDX_GEN1] = st_q.en && hit1;
        for (int i = 0; i < NUM_CNT; i++) begin
            ld_v[i] = reg_valid && reg_write && (reg_addr == 2'(i + 1));
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_v[g]),
            .ld     (ld_v[g]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .inc    (inc_v[g]),
            .cnt    (cnt_v[g]),
            .wrap   (wrap_v[g])
        );
    end

    // next-state of control/status
    always_comb begin
        logic [2:0] ack;
        logic [2:0] set;
        st_d = st_q;
        ack  = 3'b000;
        set  = {wrap_v[IDX_CYC], wrap_v[IDX_GEN1], wrap_v[IDX_GEN0]};
        if (wr_ctl) begin
            st_d.en   = reg_wdata[B_EN];
            st_d.div  = reg_wdata[B_DIV];
            st_d.ie   = reg_wdata[B_IE_LO +: 3];
            st_d.sel0 = reg_wdata[B_SEL0 +: SEL_W];
            st_d.sel1 = reg_wdata[B_SEL1 +: SEL_W];
            ack       = reg_wdata[B_OV_LO +: 3];
        end
        st_d.ovf = (st_q.ovf & ~ack) | set;
        if (clr_cyc)      st_d.presc = '0;
        else if (st_q.en) st_d.presc = st_q.presc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            2'd0: begin
                reg_rdata[B_EN]              = st_q.en;
                reg_rdata[B_DIV]             = st_q.div;
                reg_rdata[B_IE_LO +: 3]      = st_q.ie;
                reg_rdata[B_OV_LO +: 3]      = st_q.ovf;
                reg_rdata[B_SEL1 +: SEL_W]   = st_q.sel1;
                reg_rdata[B_SEL0 +: SEL_W]   = st_q.sel0;
            end
            2'd1:    reg_rdata = REG_W'(cnt_v[IDX_CYC]);
            2'd2:    reg_rdata = REG_W'(cnt_v[IDX_GEN0]);
            default: reg_rdata = REG_W'(cnt_v[IDX_GEN1]);
        endcase
    end

    assign irq = |(st_q.ovf & st_q.ie);

    // ---------------- assertions ----------------
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        localparam int FL = (g == IDX_CYC) ? F_CYC : g - 1;
        assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.ovf[FL]) |-> (cnt_v[g] == '0));
    end

    assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !reg_valid) |=> ($stable(cnt_v[IDX_CYC]) && $stable(cnt_v[IDX_GEN0])
                                      && $stable(cnt_v[IDX_GEN1])));

    assert_prescale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.div && !reg_valid && (st_q.presc != '1)) |=> $stable(cnt_v[IDX_CYC]));

    assert_gen_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_gen |=> ((cnt_v[IDX_GEN0] == '0) && (cnt_v[IDX_GEN1] == '0)));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.ovf != 3'b000));

endmodule

// File: tb/sim_perf_monitor.sv
module sim_perf_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [18:0] evt_in = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    perf_monitor u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    // ---------- reference model ----------
    logic        m_en, m_div;
    logic [2:0]  m_ie, m_ovf;     // order gen0, gen1, cycle
    logic [7:0]  m_sel0, m_sel1;
    logic [5:0]  m_presc;
    logic [31:0] m_cnt [3];       // cycle, gen0, gen1

    function automatic logic [31:0] m_read(input logic [1:0] a);
        if (a == 2'd0)
            return {4'd0, m_sel0, m_sel1, 1'b0, m_ovf, 1'b0, m_ie, m_div, 2'b00, m_en};
        return m_cnt[a - 1];
    endfunction

    function automatic logic m_hit(input logic [7:0] s, input logic [18:0] ev);
        if (s < 8'd19) return ev[s[4:0]];
        return 1'b0;
    endfunction

    task automatic m_reset();
        m_en = 0; m_div = 0; m_ie = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0; m_presc = 0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    endtask

    logic [31:0] n_cnt [3];
    logic [2:0]  n_ovf;

    task automatic m_next(input logic v, input logic w, input logic [1:0] a,
                          input logic [31:0] d, input logic [18:0] ev);
        logic wc;
        logic [2:0] inc, clr, wr, wrp;
        wc  = v && w && (a == 2'd0);
        inc[0] = m_en && (!m_div || m_presc == 6'd63);
        inc[1] = m_en && m_hit(m_sel0, ev);
        inc[2] = m_en && m_hit(m_sel1, ev);
        clr[0] = wc && d[2];
        clr[1] = wc && d[1];
        clr[2] = wc && d[1];
        for (int i = 0; i < 3; i++) begin
            wr[i]  = v && w && (a == 2'(i + 1));
            wrp[i] = 1'b0;
            n_cnt[i] = m_cnt[i];
            if (clr[i]) n_cnt[i] = 0;
            else if (wr[i]) n_cnt[i] = d;
            else if (inc[i]) begin
                wrp[i] = (m_cnt[i] == 32'hFFFF_FFFF);
                n_cnt[i] = m_cnt[i] + 1;
            end
        end
        n_ovf = m_ovf;
        if (wc) n_ovf = n_ovf & ~d[10:8];
        n_ovf = n_ovf | {wrp[0], wrp[2], wrp[1]};
    endtask

    task automatic m_apply(input logic v, input logic w, input logic [1:0] a,
                           input logic [31:0] d);
        logic wc;
        wc = v && w && (a == 2'd0);
        if (wc && d[2]) m_presc = 0;
        else if (m_en)  m_presc = m_presc + 1;
        if (wc) begin
            m_en = d[0]; m_div = d[3]; m_ie = d[6:4];
            m_sel0 = d[27:20]; m_sel1 = d[19:12];
        end
        m_ovf = n_ovf;
        for (int i = 0; i < 3; i++) m_cnt[i] = n_cnt[i];
    endtask

    // ---------- one bus cycle with checks ----------
    task automatic step(input logic v, input logic w, input logic [1:0] a,
                        input logic [31:0] d, input logic [18:0] ev, input string tag);
        @(negedge clk);
        reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d; evt_in = ev;
        #1;
        checks++;
        if (irq !== |(m_ovf & m_ie)) begin
            fails++;
            $display("FAIL R8 irq got %b exp %b", irq, |(m_ovf & m_ie));
        end
        if (v && !w) begin
            checks++;
            if (reg_rdata !== m_read(a)) begin
                fails++;
                $display("FAIL %s read addr %0d got %h exp %h", tag, a, reg_rdata, m_read(a));
            end
        end
        m_next(v, w, a, d, ev);
        @(posedge clk);
        m_apply(v, w, a, d);
    endtask

    task automatic rd(input logic [1:0] a, input logic [18:0] ev, input string tag);
        step(1, 0, a, 32'd0, ev, tag);
    endtask
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [18:0] ev,
                      input string tag);
        step(1, 1, a, d, ev, tag);
    endtask
    task automatic idle(input logic [18:0] ev);
        step(0, 0, 2'd0, 32'd0, ev, "R2");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [18:0] ALL = '1;

    initial begin
        void'($urandom(32'h5eed_2024));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R9 reset state, R1 address map
        rd(2'd0, 0, "R9"); rd(2'd1, 0, "R9"); rd(2'd2, 0, "R9"); rd(2'd3, 0, "R9");

        // R1 load, R2 nothing moves while disabled
        wr(2'd2, 32'hFFFF_FFFE, ALL, "R1");
        idle(ALL); idle(ALL);
        rd(2'd2, ALL, "R2"); rd(2'd1, ALL, "R2");

        // R4/R6/R8 gen0 on code 3, gen1 parked on 0x20, ie for gen0
        wr(2'd0, (32'd3 << 20) | (32'h20 << 12) | 32'h11, 0, "R4");
        idle(19'h8); idle(19'h8);
        rd(2'd0, ALL, "R6"); rd(2'd2, 0, "R4"); rd(2'd3, 0, "R4");

        // R7 write-one-to-clear, write-zero keeps
        wr(2'd0, (32'd3 << 20) | (32'h20 << 12) | 32'h11, 0, "R7");
        rd(2'd0, 0, "R7");
        wr(2'd0, (32'd3 << 20) | (32'h20 << 12) | 32'h111, 0, "R7");
        rd(2'd0, 0, "R7");

        // R7 set wins over clear in same cycle
        wr(2'd2, 32'hFFFF_FFFF, 0, "R1");
        wr(2'd0, (32'd3 << 20) | (32'h20 << 12) | 32'h111, 19'h8, "R7");
        rd(2'd0, 0, "R7"); rd(2'd2, 0, "R7");

        // R6 loading all-ones does not flag
        wr(2'd3, 32'hFFFF_FFFF, 0, "R6");
        rd(2'd0, 0, "R6"); rd(2'd3, 0, "R6");

        // R4 cycle code 0xFF on gen1 never counts
        wr(2'd0, (32'd3 << 20) | (32'hFF << 12) | 32'h21 | 32'h100, ALL, "R4");
        idle(ALL); idle(ALL); rd(2'd3, ALL, "R4");

        // R3/R5 prescaler with cycle reset, cycle ie set
        wr(2'd0, 32'h4D, 0, "R5");
        rd(2'd0, 0, "R5"); rd(2'd1, 0, "R5");
        repeat (140) idle(0);
        rd(2'd1, 0, "R3");
        wr(2'd0, 32'h1, 0, "R3");
        repeat (5) idle(0);
        rd(2'd1, 0, "R3");

        // R6/R8 cycle counter wrap
        wr(2'd1, 32'hFFFF_FFFD, 0, "R1");
        wr(2'd0, 32'h41, 0, "R8");
        repeat (4) idle(0);
        rd(2'd0, 0, "R6");

        // R5 general clear
        wr(2'd0, (32'd5 << 20) | (32'd6 << 12) | 32'h1, ALL, "R5");
        repeat (3) idle(ALL);
        wr(2'd0, (32'd5 << 20) | (32'd6 << 12) | 32'h3, ALL, "R5");
        rd(2'd2, ALL, "R5"); rd(2'd3, ALL, "R5"); rd(2'd0, ALL, "R5");

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            int r;
            logic [18:0] ev;
            logic [31:0] d;
            r  = $urandom % 16;
            ev = 19'($urandom);
            if (r < 8) idle(ev);
            else if (r < 11) rd(2'($urandom), ev, "R1");
            else if (r < 13) begin
                d = $urandom;
                if ($urandom % 4 != 0) d[0] = 1'b1;
                if ($urandom % 3 != 0) d[2:1] = 2'b00;
                case ($urandom % 4)
                    0: d[27:20] = 8'h20;
                    1: d[27:20] = 8'($urandom % 19);
                    2: d[27:20] = 8'hFF;
                    default: ;
                endcase
                case ($urandom % 3)
                    0: d[19:12] = 8'($urandom % 19);
                    1: d[19:12] = 8'h20;
                    default: ;
                endcase
                wr(2'd0, d, ev, "R4");
            end else begin
                d = ($urandom % 2) ? 32'hFFFF_FFFF - ($urandom % 6) : $urandom;
                wr(2'($urandom % 3 + 1), d, ev, "R1");
            end
        end
        rd(2'd0, 0, "R6"); rd(2'd1, 0, "R1"); rd(2'd2, 0, "R1"); rd(2'd3, 0, "R1");
        finish_run();
    end
endmodule